// File: doc/BRIEF.md
# Load-Locked Reservation Monitor

This block holds the single atomic-sequence reservation of one processor. A load-locked issue records the 16-byte granule it touched and arms a reservation flag. A later store-conditional is told whether it may complete. Writes made by other agents arrive on a separate snoop port, and any that land in the reserved granule cancel the reservation.

The issue port carries one operation per cycle: an operation code, a physical address, a flag saying whether the target region behaves like memory, and a valid bit. One cycle after a store-conditional is accepted, the block raises a result strobe together with a pass/fail bit. Memory, caches, address translation and the snoop transport all sit outside this block.

Top module: `llsc_resv_monitor`

## Requirements
- R1: While reset is low and in the first cycle after it, `sc_done` is 0. A store-conditional issued after reset with no earlier load-locked fails.
- R2: Operation codes on `iss_op` are 00 plain load, 01 load-locked, 10 store-conditional and 11 plain store. A store-conditional accepted at clock edge N raises `sc_done` for exactly the cycle after edge N, and for no other cycle. `sc_pass` is 1 only when a memory-like load-locked to the same granule came before it and nothing cancelled that reservation in between.
- R3: Every store-conditional consumes the reservation, whether it passes or fails. A second store-conditional with no new load-locked between them fails.
- R4: A new load-locked replaces any earlier reservation. After it, a store-conditional to the old granule fails and one to the new granule passes.
- R5: The granule is the naturally aligned 16-byte block, so address bits [3:0] are ignored. A store-conditional to a different granule fails and clears the reservation.
- R6: A snooped remote write (`snp_valid`) into the reserved granule cancels the reservation. A remote write to any other granule has no effect on it.
- R7: A remote write to the reserved granule in the same cycle as a local store-conditional makes that store-conditional fail.
- R8: A load-locked with `iss_memlike` = 0 leaves no valid reservation, and it also drops any earlier reservation.
- R9: Local plain loads and plain stores, including stores into the reserved granule, leave the reservation intact.
- R10: A remote write in the same cycle as a load-locked counts as ordered before it and does not cancel the new reservation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | An operation is issued this cycle |
| iss_op | input | 2 | Operation code (00 load, 01 load-locked, 10 store-conditional, 11 store) |
| iss_addr | input | ADDR_W | Physical address of the issued operation |
| iss_memlike | input | 1 | Target region is memory-like |
| snp_valid | input | 1 | A remote write is observed this cycle |
| snp_addr | input | ADDR_W | Physical address of the remote write |
| sc_done | output | 1 | Store-conditional result strobe |
| sc_pass | output | 1 | Store-conditional succeeded (valid with `sc_done`) |

## Verification
The hardest case to reach from the ports is a collision: a remote write must land in the reserved granule in the exact cycle of the local store-conditional, or in the exact cycle of a new load-locked. In both cases the outcome depends on which event is treated as first. Directed sequences place the snoop in those exact cycles, using addresses that share a granule but differ in their low four bits. A randomized phase then draws addresses from two neighbouring granules, so that hits, misses and collisions occur often. A cycle-level reference model checks every result strobe.

// File: rtl/llsc_pkg.sv
// Shared types for the reservation monitor.
// Assumes a 2-bit operation code driven by the issue stage.
package llsc_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'b00,
        OP_LL    = 2'b01,
        OP_SC    = 2'b10,
        OP_STORE = 2'b11
    } llsc_op_e;

endpackage

// File: rtl/llsc_tag_cmp.sv
// Equality comparator for two granule tags.
// Each bit is compared on its own, and the results are AND-reduced.
// Assumes both tags are already stripped of their low granule bits.
module llsc_tag_cmp #(
    parameter int TAG_W = 28
) (
    input  logic [TAG_W-1:0] tag_a,
    input  logic [TAG_W-1:0] tag_b,
    output logic             same
);

    logic [TAG_W-1:0] bit_eq;

    // per-bit equality, one comparator per tag bit
    for (genvar g = 0; g < TAG_W; g++) begin : g_bit
        assign bit_eq[g] = ~(tag_a[g] ^ tag_b[g]);
    end

    // all bits must agree
    assign same = &bit_eq;

endmodule

// File: rtl/llsc_resv_reg.sv
// Holds the reservation flag and the tag of the reserved granule.
// Assumes a load-locked and a store-conditional never arrive in the same cycle,
// because the issue port carries one operation per cycle.
module llsc_resv_reg #(
    parameter int TAG_W = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ll_fire,
    input  logic             ll_mem,
    input  logic [TAG_W-1:0] ll_tag,
    input  logic             sc_fire,
    input  logic             snoop_hit,
    output logic             resv_vld,
    output logic [TAG_W-1:0] resv_tag
);

    // arm on load-locked; drop on store-conditional or a remote hit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resv_vld <= 1'b0;
            resv_tag <= '0;
        end else if (ll_fire) begin
            resv_vld <= ll_mem;
            resv_tag <= ll_tag;
        end else if (sc_fire || snoop_hit) begin
            resv_vld <= 1'b0;
        end
    end

endmodule

// File: rtl/llsc_result_stage.sv
// Registers the store-conditional verdict and presents it one cycle later.
// Assumes pass_now is only meaningful while sc_fire is high.
module llsc_result_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic sc_fire,
    input  logic pass_now,
    output logic sc_done,
    output logic sc_pass
);

    // capture strobe and verdict
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sc_done <= 1'b0;
            sc_pass <= 1'b0;
        end else begin
            sc_done <= sc_fire;
            sc_pass <= sc_fire & pass_now;
        end
    end

endmodule

// File: rtl/llsc_resv_monitor.sv
// Reservation monitor for load-locked / store-conditional on one processor.
// Decodes the issue port, compares granule tags for local and snooped
// addresses, keeps the reservation, and reports the store-conditional result
// one cycle after acceptance.
// Assumes: at most one issued operation per cycle; snoops never carry this
// processor's own writes.
module llsc_resv_monitor #(
    parameter int ADDR_W   = 32,
    parameter int GRAN_LSB = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic [1:0]        iss_op,
    input  logic [ADDR_W-1:0] iss_addr,
    input  logic              iss_memlike,
    input  logic              snp_valid,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              sc_done,
    output logic              sc_pass
);
    import llsc_pkg::*;

    localparam int TAG_W = ADDR_W - GRAN_LSB;

    llsc_op_e         op;
    logic             ll_fire;
    logic             sc_fire;
    logic [TAG_W-1:0] iss_tag;
    logic [TAG_W-1:0] snp_tag;
    logic             resv_vld;
    logic [TAG_W-1:0] resv_tag;
    logic             iss_same;
    logic             snp_same;
    logic             snoop_hit;
    logic             pass_now;

    // decode the issued operation
    always_comb begin
        op      = llsc_op_e'(iss_op);
        ll_fire = iss_valid && (op == OP_LL);
        sc_fire = iss_valid && (op == OP_SC);
    end

    assign iss_tag = iss_addr[ADDR_W-1:GRAN_LSB];
    assign snp_tag = snp_addr[ADDR_W-1:GRAN_LSB];

    llsc_tag_cmp #(.TAG_W(TAG_W)) u_iss_cmp (
        .tag_a (iss_tag),
        .tag_b (resv_tag),
        .same  (iss_same)
    );

    llsc_tag_cmp #(.TAG_W(TAG_W)) u_snp_cmp (
        .tag_a (snp_tag),
        .tag_b (resv_tag),
        .same  (snp_same)
    );

    // a remote write into the live granule; it wins over a same-cycle SC
    always_comb begin
        snoop_hit = snp_valid && resv_vld && snp_same;
        pass_now  = resv_vld && iss_same && !snoop_hit;
    end

    llsc_resv_reg #(.TAG_W(TAG_W)) u_resv (
        .clk       (clk),
        .rst_n     (rst_n),
        .ll_fire   (ll_fire),
        .ll_mem    (iss_memlike),
        .ll_tag    (iss_tag),
        .sc_fire   (sc_fire),
        .snoop_hit (snoop_hit),
        .resv_vld  (resv_vld),
        .resv_tag  (resv_tag)
    );

    llsc_result_stage u_result (
        .clk      (clk),
        .rst_n    (rst_n),
        .sc_fire  (sc_fire),
        .pass_now (pass_now),
        .sc_done  (sc_done),
        .sc_pass  (sc_pass)
    );

    AST_DONE_AFTER_SC: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_op == 2'b10) |=> sc_done); // R2
    AST_NO_STRAY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !(iss_valid && iss_op == 2'b10) |=> !sc_done); // R2
    AST_PASS_NEEDS_RESV: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_op == 2'b10 && !resv_vld) |=> !sc_pass); // R1
    AST_SC_CONSUMES: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_op == 2'b10) |=> !resv_vld); // R3
    AST_SNOOP_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && resv_vld && snp_same && !ll_fire) |=> !resv_vld); // R6
    AST_COLLIDE_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_fire && snp_valid && snp_tag == iss_tag) |=> !sc_pass); // R7
    AST_NONMEM_NO_RESV: assert property (@(posedge clk) disable iff (!rst_n)
        (ll_fire && !iss_memlike) |=> !resv_vld); // R8
    AST_PLAIN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (resv_vld && !snp_valid && iss_valid && iss_op[0] == iss_op[1])
        |=> (resv_vld && $stable(resv_tag))); // R9

endmodule

// File: tb/tb_llsc_resv_monitor.sv
`timescale 1ns/1ps
module tb_llsc_resv_monitor;

    localparam int AW = 32;
    localparam logic [1:0] LD = 2'b00, LL = 2'b01, SC = 2'b10, ST = 2'b11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          iss_valid = 1'b0;
    logic [1:0]    iss_op = LD;
    logic [AW-1:0] iss_addr = '0;
    logic          iss_memlike = 1'b1;
    logic          snp_valid = 1'b0;
    logic [AW-1:0] snp_addr = '0;
    logic          sc_done;
    logic          sc_pass;

    int checks = 0;
    int errors = 0;

    // reference state
    bit            m_vld = 0;
    logic [AW-5:0] m_tag = '0;

    always #2 clk = ~clk;

    llsc_resv_monitor dut (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_addr(iss_addr), .iss_memlike(iss_memlike), .snp_valid(snp_valid),
        .snp_addr(snp_addr), .sc_done(sc_done), .sc_pass(sc_pass)
    );

    task automatic check(input string req, input logic act_d, input logic act_p,
                         input bit exp_d, input bit exp_p);
        checks++;
        if (act_d !== exp_d || (exp_d && act_p !== exp_p)) begin
            errors++;
            $display("FAIL %s done/pass actual %b/%b expected %b/%b at %0t",
                     req, act_d, act_p, exp_d, exp_p, $time);
        end
    endtask

    // one cycle: drive at negedge, model at posedge, compare at next negedge
    task automatic step(input string req, input bit v, input logic [1:0] op,
                        input logic [AW-1:0] a, input bit mem,
                        input bit sv, input logic [AW-1:0] sa);
        bit e_d, e_p, hit;
        iss_valid = v; iss_op = op; iss_addr = a; iss_memlike = mem;
        snp_valid = sv; snp_addr = sa;
        @(posedge clk);
        hit = sv && m_vld && (sa[AW-1:4] == m_tag);
        e_d = v && op == SC;
        e_p = e_d && m_vld && (a[AW-1:4] == m_tag) && !hit;
        if (v && op == LL) begin
            m_vld = mem;
            m_tag = a[AW-1:4];
        end else if ((v && op == SC) || hit) begin
            m_vld = 0;
        end
        @(negedge clk);
        check(req, sc_done, sc_pass, e_d, e_p);
    endtask

    task automatic iss(input string req, input logic [1:0] op, input logic [AW-1:0] a);
        step(req, 1, op, a, 1, 0, '0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [AW-1:0] A, B;
        A = 32'h0000_1230;
        B = 32'h0000_1240;
        repeat (3) @(negedge clk);
        check("R1", sc_done, sc_pass, 0, 0);
        rst_n = 1'b1;
        step("R1", 0, LD, '0, 1, 0, '0);
        iss("R1", SC, A);                            // no LL yet: fail
        iss("R2", LL, A + 3);
        iss("R5", SC, A + 12);                       // same granule: pass
        iss("R3", SC, A);                            // consumed: fail
        iss("R4", LL, A); iss("R4", LL, B);
        iss("R4", SC, A);                            // replaced: fail
        iss("R4", LL, B); iss("R4", SC, B + 15);     // pass
        iss("R5", LL, A); iss("R5", SC, B);          // other granule: fail
        iss("R5", SC, A);                            // cleared: fail
        iss("R6", LL, A);
        step("R6", 0, LD, '0, 1, 1, A + 8);          // remote hit
        iss("R6", SC, A);                            // fail
        iss("R6", LL, A);
        step("R6", 0, LD, '0, 1, 1, B);              // remote miss
        iss("R6", SC, A);                            // pass
        iss("R7", LL, A);
        step("R7", 1, SC, A, 1, 1, A + 4);           // collision: fail
        step("R8", 1, LL, A, 0, 0, '0); iss("R8", SC, A);
        iss("R8", LL, A); step("R8", 1, LL, A, 0, 0, '0);
        iss("R8", SC, A);                            // fail
        iss("R9", LL, A); iss("R9", ST, A + 4); iss("R9", LD, A);
        iss("R9", SC, A);                            // pass
        step("R10", 1, LL, A, 1, 1, A);              // snoop with LL
        iss("R10", SC, A);                           // pass
        for (int i = 0; i < 2000; i++) begin
            logic [1:0] rop;
            rop = 2'($urandom_range(0, 3));
            step("R2", 1'($urandom_range(0, 1)), rop,
                 32'h1230 + 32'($urandom_range(0, 31)), 1'($urandom_range(0, 4) != 0),
                 1'($urandom_range(0, 3) == 0), 32'h1230 + 32'($urandom_range(0, 31)));
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule